// File: doc/BRIEF.md
# Power-Up Start Vector Selector

This block runs once after reset is released and chooses where a 16-bit processor begins. It reads two option straps and four boot-address straps a single time. From them it chooses one of four start policies. Three of these hand a program counter (PC) and processor status word (PS) to normal execution, which may service pending interrupts before it executes at PC. The fourth sends the processor to its console debug monitor.

Two policies need no memory. One uses a fixed boot ROM address with a fixed priority level. The other builds the PC from the boot straps, so the start lies on a 2048-word boundary. The last policy fetches a two-word start vector from fixed low memory over a request/acknowledge read port. A bus timeout aborts that fetch and raises an error flag.

Top module: `pwrup_vector_sel`

## Requirements
- R1: While `rst_n` is low, `pc` and `ps` are 0, `done`, `debug_mode` and `fetch_err` are 0, and `rd_req` is 0.
- R2: The straps are captured on the first rising clock edge after `rst_n` goes high. Later changes to any strap have no effect on the outcome.
- R3: The option code is the bitwise inverse of `opt_strap_fitted`, where a fitted strap reads 1. Bit 1 of the strap input gives bit 1 of the code, so a code bit is 1 when its strap is absent.
- R4: Code 0 reads address 24 (octal) first and loads the returned word into PC. It then reads address 26 (octal) and loads that word into PS. `done` is high in the cycle after the acknowledge of the second read.
- R5: `rd_req` stays high with `rd_addr` unchanged until `rd_ack` or `rd_timeout` is seen. Each acknowledged read takes one cycle more than its wait, so with zero wait `done` appears four cycles after reset release.
- R6: If `rd_timeout` arrives during a fetch, it wins over `rd_ack`. `fetch_err` then goes high and stays high, `rd_req` drops, and `done` never asserts. PC keeps a word fetched before the timeout.
- R7: Code 1 clears PS and raises `debug_mode` two cycles after reset release. It makes no memory read and never asserts `done`.
- R8: Code 2 loads PC with 173000 (octal) and PS with 340 (octal), and pulses `done` two cycles after reset release.
- R9: Code 3 loads PC[15:12] from `boot_strap_fitted[3:0]` (fitted strap = 1, bit 3 to PC[15]). It clears PC[11:0], sets PS to 340 (octal), and pulses `done` two cycles after reset release.
- R10: `done` is a single-cycle pulse. After the sequence ends, `pc`, `ps`, `debug_mode` and `fetch_err` hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opt_strap_fitted | input | 2 | Option straps, 1 = fitted |
| boot_strap_fitted | input | 4 | Boot-address straps, 1 = fitted |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 16 | Read data |
| rd_timeout | input | 1 | Bus timeout for the current read |
| pc | output | 16 | Start program counter |
| ps | output | 16 | Start processor status |
| done | output | 1 | Start-execution strobe |
| debug_mode | output | 1 | Enter console debug mode |
| fetch_err | output | 1 | Vector fetch aborted by timeout |

## Verification
The hardest cases to reach from the ports are the fetch interrupted partway and the strap change made after the sample. The bench therefore models memory with a programmable wait and injects a timeout on either the first or the second vector read. In every run it also flips all straps one cycle after reset release. It sweeps all four option codes with all sixteen boot patterns and several memory latencies. Each run is compared against a PC, PS, ending flag and finishing cycle computed from the requirements.

// File: rtl/pwrup_vector_sel.sv
module pwrup_vector_sel #(
  parameter int PC_W      = 16,
  parameter int BOOT_BITS = 4,
  parameter logic [PC_W-1:0] VEC_ADDR = PC_W'('o24),
  parameter logic [PC_W-1:0] ROM_PC   = PC_W'('o173000),
  parameter logic [PC_W-1:0] RUN_PS   = PC_W'('o340)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           opt_strap_fitted,
  input  logic [BOOT_BITS-1:0] boot_strap_fitted,
  output logic                 rd_req,
  output logic [PC_W-1:0]      rd_addr,
  input  logic                 rd_ack,
  input  logic [PC_W-1:0]      rd_data,
  input  logic                 rd_timeout,
  output logic [PC_W-1:0]      pc,
  output logic [PC_W-1:0]      ps,
  output logic                 done,
  output logic                 debug_mode,
  output logic                 fetch_err
);
  localparam int LOW_W = PC_W - BOOT_BITS;
  localparam logic [PC_W-1:0] PS_ADDR = VEC_ADDR + PC_W'(2);

  typedef enum logic [2:0] {S_SAMPLE, S_DISPATCH, S_RD_PC, S_RD_PS, S_IDLE} state_t;

  state_t               st;
  logic [1:0]           code_q;
  logic [BOOT_BITS-1:0] boot_q;

  assign rd_req  = (st == S_RD_PC) || (st == S_RD_PS);
  assign rd_addr = (st == S_RD_PS) ? PS_ADDR : VEC_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_SAMPLE;
      code_q     <= '0;
      boot_q     <= '0;
      pc         <= '0;
      ps         <= '0;
      done       <= 1'b0;
      debug_mode <= 1'b0;
      fetch_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_SAMPLE: begin
          code_q <= ~opt_strap_fitted;
          boot_q <= boot_strap_fitted;
          st     <= S_DISPATCH;
        end
        S_DISPATCH: begin
          case (code_q)
            2'd0: st <= S_RD_PC;
            2'd1: begin
              ps         <= '0;
              debug_mode <= 1'b1;
              st         <= S_IDLE;
            end
            2'd2: begin
              pc   <= ROM_PC;
              ps   <= RUN_PS;
              done <= 1'b1;
              st   <= S_IDLE;
            end
            default: begin
              pc   <= {boot_q, {LOW_W{1'b0}}};
              ps   <= RUN_PS;
              done <= 1'b1;
              st   <= S_IDLE;
            end
          endcase
        end
        S_RD_PC: begin
          if (rd_timeout) begin
            fetch_err <= 1'b1;
            st        <= S_IDLE;
          end else if (rd_ack) begin
            pc <= rd_data;
            st <= S_RD_PS;
          end
        end
        S_RD_PS: begin
          if (rd_timeout) begin
            fetch_err <= 1'b1;
            st        <= S_IDLE;
          end else if (rd_ack) begin
            ps   <= rd_data;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwrup_vector_sel_chk.sv
module pwrup_vector_sel_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic [PC_W-1:0] rd_addr,
  input logic            rd_ack,
  input logic            rd_timeout,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] ps,
  input logic            done,
  input logic            debug_mode,
  input logic            fetch_err
);
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !rd_timeout |=> rd_req && $stable(rd_addr));

  a_r6_timeout_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_timeout |=> !rd_req && fetch_err && !done);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |=> fetch_err && !done);

  a_r7_debug_ps_clear: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode |-> ps == '0 && !done && !rd_req);

  a_r7_debug_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode |=> debug_mode);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && $stable(pc) && $stable(ps) && !rd_req);
endmodule

bind pwrup_vector_sel pwrup_vector_sel_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/tb_pwrup_vector_sel.sv
module tb_pwrup_vector_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  opt_strap_fitted = '0;
  logic [3:0]  boot_strap_fitted = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic        rd_timeout = 1'b0;
  logic [15:0] pc, ps;
  logic        done, debug_mode, fetch_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwrup_vector_sel dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
    end
  endtask

  // to_at: 0 none, 1 timeout on PC read, 2 timeout on PS read
  task automatic run_case(input logic [1:0] code, input logic [3:0] boot,
                          input int lat, input int to_at,
                          input logic [15:0] dpc, input logic [15:0] dps);
    int reads = 0, waitc = 0, donecnt = 0, done_cyc = 0, dbg_cyc = 0, err_cyc = 0;
    int bad_addr = 0;
    logic [15:0] epc, eps;
    int ecyc;
    rst_n = 1'b0;
    opt_strap_fitted  = ~code;
    boot_strap_fitted = boot;
    rd_ack = 0; rd_timeout = 0; rd_data = '0;
    repeat (2) @(negedge clk);
    chk(pc == 0 && ps == 0 && !done && !debug_mode && !fetch_err && !rd_req,
        "R1", "reset state", {pc, ps}, 32'd0);
    rst_n = 1'b1;
    for (int cyc = 1; cyc <= 40; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        opt_strap_fitted  = ~opt_strap_fitted;
        boot_strap_fitted = ~boot;
      end
      rd_ack = 0; rd_timeout = 0;
      if (done) begin donecnt++; if (done_cyc == 0) done_cyc = cyc; end
      if (debug_mode && dbg_cyc == 0) dbg_cyc = cyc;
      if (fetch_err && err_cyc == 0) err_cyc = cyc;
      if (rd_req) begin
        if (rd_addr != ((reads == 0) ? 16'o24 : 16'o26)) bad_addr++;
        if (waitc == lat) begin
          waitc = 0;
          if (to_at == reads + 1) begin
            rd_timeout = 1'b1;
            rd_ack = 1'b1;
          end else begin
            rd_ack  = 1'b1;
            rd_data = (reads == 0) ? dpc : dps;
            reads++;
          end
        end else waitc++;
      end
    end
    rd_ack = 0; rd_timeout = 0;

    case (code)
      2'd0: begin
        epc = (to_at == 1) ? 16'd0 : dpc;
        eps = (to_at == 0) ? dps : 16'd0;
      end
      2'd1: begin epc = 16'd0; eps = 16'd0; end
      2'd2: begin epc = 16'o173000; eps = 16'o340; end
      default: begin epc = {boot, 12'd0}; eps = 16'o340; end
    endcase
    ecyc = (code == 0) ? 4 + 2 * lat : 2;

    if (code == 0) begin
      chk(bad_addr == 0, "R4", "vector address order", bad_addr, 0);
      chk(reads == ((to_at == 0) ? 2 : to_at - 1), "R4", "acknowledged reads", reads,
          (to_at == 0) ? 2 : to_at - 1);
      if (to_at == 0) begin
        chk(done_cyc == ecyc, "R5", "done cycle", done_cyc, ecyc);
        chk(!fetch_err, "R4", "no error", fetch_err, 0);
      end else begin
        chk(fetch_err && donecnt == 0, "R6", "timeout error, no done",
            {fetch_err, 8'(donecnt)}, 9'h100);
        chk(err_cyc == 3 + lat + (to_at - 1) * (lat + 1), "R6", "error cycle", err_cyc,
            3 + lat + (to_at - 1) * (lat + 1));
      end
      chk(pc == epc, "R4", "pc from vector", pc, epc);
      chk(ps == eps, "R4", "ps from vector", ps, eps);
    end else if (code == 1) begin
      chk(debug_mode && dbg_cyc == 2, "R7", "debug entry cycle", dbg_cyc, 2);
      chk(donecnt == 0 && reads == 0 && ps == 0, "R7", "no done/read, ps clear",
          donecnt + reads + ps, 0);
    end else begin
      chk(pc == epc, (code == 2) ? "R8" : "R9", "pc", pc, epc);
      chk(ps == eps, (code == 2) ? "R8" : "R9", "ps", ps, eps);
      chk(done_cyc == 2 && reads == 0, "R2", "done cycle, no reads", done_cyc, 2);
    end
    chk(donecnt == ((code != 1 && to_at == 0) ? 1 : 0), "R10", "done pulse count",
        donecnt, (code != 1 && to_at == 0) ? 1 : 0);
    chk(!(debug_mode && fetch_err) && debug_mode == (code == 1), "R3", "code decode",
        {debug_mode, fetch_err}, {code == 1, 1'b0});
  endtask

  initial begin
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 16; b++)
        run_case(2'(c), 4'(b), 0, 0, 16'(b * 16'h1111) ^ 16'o1234, 16'(b * 16'h0101) ^ 16'o340);
    for (int lat = 0; lat < 4; lat++)
      for (int t = 0; t < 3; t++)
        run_case(2'd0, 4'(lat), lat, t, 16'hA5A5 ^ 16'(lat), 16'h5A5A ^ 16'(t));
    run_case(2'd0, 4'hF, 2, 0, 16'hFFFF, 16'h0000);
    run_case(2'd0, 4'h0, 1, 0, 16'h0000, 16'hFFFF);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule